// File: doc/BRIEF.md
# Sequential Breakpoint and Branch Trace Unit

This debug block watches a bus-cycle monitor port and raises a break request when a cycle meets the conditions programmed into one of four comparator channels. The channels are named A, B, C and D. Each channel compares the cycle's address under a per-bit ignore mask. It can also require a given bus master (CPU or DMA), a given cycle kind (instruction fetch or data access), a read or a write, and an operand size. Each of these conditions has its own don't-care enable. Channels C and D can also compare the data word. They also carry a pass counter, so a break fires only on the Nth qualifying match.

The channels either break on their own or form an ordered chain. Three chains are available: A, B, C, D; B, C, D; and C, D. In a chain, only the channel the sequence is waiting for can advance it. The break comes only from D, after the earlier channels have matched in order. Channels in front of the chain's first member keep breaking on their own. For fetch breaks, a per-channel flag reports whether the break applies before or after the instruction executes. Halting the pipeline is left to the consumer of that flag.

The block also keeps a four-entry ring of branch source and destination pairs. When full, a new pair overwrites the oldest one. A combinational read port indexes the ring from the newest pair to the oldest. Software programs everything through a simple write port.

Top module: `brk_trace_unit`

## Requirements
- R1: A channel matches only when every address bit not set in its mask equals the compare address; mask bits set to 1 are ignored.
- R2: Control word bits: 0 enable, 1/2 care and value for master (1 = DMA), 3/4 care and value for kind (1 = fetch), 5/6 care and value for direction (1 = write), 7 and 9:8 care and value for size (0 byte, 1 word, 2 longword). A condition whose care bit is 0 does not affect the match. A disabled channel never matches.
- R3: Control bit 11 enables a data compare against the data register. This works only on C and D. On A and B, that bit and writes to the data register have no effect.
- R4: With the sequence mode at 0, any matching channel raises `brk_irq` for one cycle in the cycle after the monitored cycle. When several channels match together, `brk_chan` reports the lowest-numbered one (A=0 … D=3).
- R5: Sequence mode 1 chains A, B, C, D. A chain member's match counts only while the sequence waits on it. The break is reported as channel D once D matches after A, B and C have matched in that order.
- R6: Mode 2 chains B, C, D, and mode 3 chains C, D. Channels in front of the chain's first member keep breaking independently.
- R7: The sequence returns to the chain's first channel after a chained break, and whenever the mode register (address 16) is written.
- R8: On C and D, control bits 27:16 set a pass count N. Only every Nth match the channel is armed for counts as a hit, and the count restarts afterwards. N = 0 acts as 1. Writing the channel's control word clears its count.
- R9: `brk_after` is 1 with a break only when the breaking channel's control bit 10 is set and the monitored cycle was a fetch. Otherwise it is 0.
- R10: Each `br_valid` pulse stores a source/destination pair into a four-entry ring. `trc_idx` 0 reads the newest pair, and `trc_valid` is 1 only for indices below the number of stored pairs (at most 4).
- R11: After reset, no break is pending, the mode is 0, no trace pair is valid, and all channels are disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| mon_valid | input | 1 | Monitored bus cycle present |
| mon_addr | input | W | Cycle address |
| mon_data | input | W | Cycle data |
| mon_dma | input | 1 | 1 = DMA master, 0 = CPU |
| mon_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| mon_write | input | 1 | 1 = write, 0 = read |
| mon_size | input | 2 | 0 byte, 1 word, 2 longword |
| br_valid | input | 1 | Branch pair to record |
| br_src | input | W | Branch source address |
| br_dst | input | W | Branch destination address |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register address: channel*4 + {0 addr, 1 mask, 2 control, 3 data}; 16 mode |
| cfg_wdata | input | W | Register write data |
| brk_irq | output | 1 | Break request pulse |
| brk_chan | output | 2 | Channel that caused the break |
| brk_after | output | 1 | Fetch break applies after execution |
| trc_idx | input | log2(TD) | Trace read index, 0 = newest |
| trc_valid | output | 1 | Indexed pair is stored |
| trc_src | output | W | Indexed branch source |
| trc_dst | output | W | Indexed branch destination |

## Verification
On every cycle, the assertions check the following. A break only follows a monitored cycle. The after-execution flag only accompanies a break that came from a fetch. The sequence pointer restarts on a mode write and never leaves the active chain. The pass counters stay below their limits, and the trace fill count grows by one per branch up to four. The bench scenarios cover the rest: masked address matching, each condition's don't-care, data compare on C and D only, ordering within chains, Nth-pass breaking, and newest-first readout after the ring wraps. A reference model compares all of these against the outputs over directed and random bus cycles.

// File: rtl/brk_trace_unit.sv
module brk_trace_unit #(
  parameter int W  = 32,
  parameter int CW = 12,
  parameter int TD = 4,
  localparam int PW = $clog2(TD)
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mon_valid,
  input  logic [W-1:0]  mon_addr,
  input  logic [W-1:0]  mon_data,
  input  logic          mon_dma,
  input  logic          mon_fetch,
  input  logic          mon_write,
  input  logic [1:0]    mon_size,
  input  logic          br_valid,
  input  logic [W-1:0]  br_src,
  input  logic [W-1:0]  br_dst,
  input  logic          cfg_we,
  input  logic [4:0]    cfg_addr,
  input  logic [W-1:0]  cfg_wdata,
  output logic          brk_irq,
  output logic [1:0]    brk_chan,
  output logic          brk_after,
  input  logic [PW-1:0] trc_idx,
  output logic          trc_valid,
  output logic [W-1:0]  trc_src,
  output logic [W-1:0]  trc_dst
);

  logic [W-1:0]  c_addr [4];
  logic [W-1:0]  c_mask [4];
  logic [11:0]   c_ctrl [4];
  logic [W-1:0]  c_data [2];
  logic [CW-1:0] c_lim  [2];
  logic [1:0]    mode, seq_ptr, first_sel, chan_n;
  logic [3:0]    match, dmatch, last, hit, fire, in_chain, armed;

  function automatic logic [1:0] first_of(input logic [1:0] m);
    return (m == 2'd0) ? 2'd0 : m - 2'd1;
  endfunction

  assign first_sel = first_of(mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= 2'd0;
      for (int k = 0; k < 4; k++) begin
        c_addr[k] <= '0;
        c_mask[k] <= '0;
        c_ctrl[k] <= '0;
      end
      for (int k = 0; k < 2; k++) begin
        c_data[k] <= '0;
        c_lim[k]  <= '0;
      end
    end else if (cfg_we) begin
      if (cfg_addr == 5'd16) mode <= cfg_wdata[1:0];
      else if (!cfg_addr[4]) begin
        case (cfg_addr[1:0])
          2'd0: c_addr[cfg_addr[3:2]] <= cfg_wdata;
          2'd1: c_mask[cfg_addr[3:2]] <= cfg_wdata;
          2'd2: begin
            c_ctrl[cfg_addr[3:2]] <= cfg_wdata[11:0];
            if (cfg_addr[3]) c_lim[cfg_addr[2]] <= cfg_wdata[16 +: CW];
          end
          default: if (cfg_addr[3]) c_data[cfg_addr[2]] <= cfg_wdata;
        endcase
      end
    end
  end

  logic unused_bits;
  assign unused_bits = ^{cfg_wdata[15:12], cfg_wdata[W-1:16+CW], c_ctrl[0][11], c_ctrl[1][11]};

  for (genvar i = 0; i < 4; i++) begin : g_ch
    localparam logic [1:0] IDX = 2'(i);
    logic [11:0] ct;
    assign ct = c_ctrl[i];
    assign match[i] = mon_valid & ct[0]
                    & (((mon_addr ^ c_addr[i]) & ~c_mask[i]) == '0)
                    & (!ct[1] | (ct[2] == mon_dma))
                    & (!ct[3] | (ct[4] == mon_fetch))
                    & (!ct[5] | (ct[6] == mon_write))
                    & (!ct[7] | (ct[9:8] == mon_size))
                    & dmatch[i];
    assign in_chain[i] = (mode != 2'd0) && (IDX >= first_sel);
    assign armed[i]    = !in_chain[i] || (seq_ptr == IDX);
    assign hit[i]      = match[i] & armed[i] & last[i];
    assign fire[i]     = hit[i] & (!in_chain[i] | (IDX == 2'd3));

    if (i >= 2) begin : g_cnt
      logic [CW-1:0] cnt, lim;
      assign lim = (c_lim[i-2] == '0) ? CW'(1) : c_lim[i-2];
      assign dmatch[i] = !ct[11] | (mon_data == c_data[i-2]);
      assign last[i] = ({1'b0, cnt} + 1'b1) >= {1'b0, lim};
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt <= '0;
        else if (cfg_we && cfg_addr == {1'b0, IDX, 2'd2}) cnt <= '0;
        else if (match[i] && armed[i]) cnt <= last[i] ? '0 : cnt + 1'b1;
      end
      AST_CNT_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < lim); // R8
    end else begin : g_plain
      assign dmatch[i] = 1'b1;
      assign last[i]   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seq_ptr <= 2'd0;
    else if (cfg_we && cfg_addr == 5'd16) seq_ptr <= first_of(cfg_wdata[1:0]);
    else if (hit[seq_ptr] && in_chain[seq_ptr])
      seq_ptr <= (seq_ptr == 2'd3) ? first_sel : seq_ptr + 2'd1;
  end

  assign chan_n = fire[0] ? 2'd0 : fire[1] ? 2'd1 : fire[2] ? 2'd2 : 2'd3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      brk_irq   <= 1'b0;
      brk_chan  <= 2'd0;
      brk_after <= 1'b0;
    end else begin
      brk_irq   <= |fire;
      brk_chan  <= chan_n;
      brk_after <= (|fire) & c_ctrl[chan_n][10] & mon_fetch;
    end
  end

  logic [W-1:0]  t_src [TD];
  logic [W-1:0]  t_dst [TD];
  logic [PW-1:0] wp, rd;
  logic [PW:0]   tcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp   <= '0;
      tcnt <= '0;
      for (int k = 0; k < TD; k++) begin
        t_src[k] <= '0;
        t_dst[k] <= '0;
      end
    end else if (br_valid) begin
      t_src[wp] <= br_src;
      t_dst[wp] <= br_dst;
      wp <= wp + 1'b1;
      if (tcnt < (PW+1)'(TD)) tcnt <= tcnt + 1'b1;
    end
  end

  assign rd        = wp - PW'(1) - trc_idx;
  assign trc_valid = {1'b0, trc_idx} < tcnt;
  assign trc_src   = t_src[rd];
  assign trc_dst   = t_dst[rd];

  AST_IRQ_AFTER_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    !mon_valid |=> !brk_irq); // R4
  AST_AFTER_NEEDS_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    brk_after |-> brk_irq && $past(mon_fetch)); // R9
  AST_SEQ_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == 5'd16) |=> seq_ptr == first_of($past(cfg_wdata[1:0]))); // R7
  AST_SEQ_IN_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'd0) |-> seq_ptr >= first_sel); // R6
  AST_TRC_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && tcnt < (PW+1)'(TD)) |=> tcnt == $past(tcnt) + 1'b1); // R10
  AST_TRC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    tcnt <= (PW+1)'(TD)); // R10

endmodule

// File: tb/test_brk_trace_unit.sv
module test_brk_trace_unit;
  logic clk = 0, rst_n = 0;
  logic mon_valid = 0, mon_dma = 0, mon_fetch = 0, mon_write = 0;
  logic [31:0] mon_addr = 0, mon_data = 0, br_src = 0, br_dst = 0, cfg_wdata = 0;
  logic [1:0] mon_size = 0;
  logic br_valid = 0, cfg_we = 0;
  logic [4:0] cfg_addr = 0;
  logic brk_irq, brk_after, trc_valid;
  logic [1:0] brk_chan, trc_idx = 0;
  logic [31:0] trc_src, trc_dst;

  brk_trace_unit i_brk_trace_unit (.*);

  always #10 clk = ~clk;

  int errors = 0, checks = 0;
  bit done = 0;
  logic [31:0] sa [4], sm [4], sc [4], sd [4];
  int mcnt [4];
  int mmode = 0, mptr = 0;
  logic [31:0] rs [$], rdst [$];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] ctl(bit en, bit cm, bit m, bit ck, bit k, bit cr, bit r,
                                      bit cs, logic [1:0] s, bit aft, bit cd, logic [11:0] lim);
    return {4'd0, lim, 4'd0, cd, aft, s, cs, r, cr, k, ck, m, cm, en};
  endfunction

  function automatic int first_of(int m);
    return (m == 0) ? 0 : m - 1;
  endfunction

  function automatic bit m_match(int i, logic [31:0] a, logic [31:0] d, bit dma, bit f, bit w, logic [1:0] s);
    logic [31:0] c = sc[i];
    if (!c[0]) return 0;
    if (((a ^ sa[i]) & ~sm[i]) != 0) return 0;
    if (c[1] && c[2] != dma) return 0;
    if (c[3] && c[4] != f) return 0;
    if (c[5] && c[6] != w) return 0;
    if (c[7] && c[9:8] != s) return 0;
    if (i >= 2 && c[11] && d != sd[i]) return 0;
    return 1;
  endfunction

  task automatic cfg(input logic [4:0] a, input logic [31:0] v);
    cfg_we = 1; cfg_addr = a; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 0;
    if (a == 16) begin mmode = v[1:0]; mptr = first_of(mmode); end
    else if (a < 16) begin
      case (a[1:0])
        0: sa[a[3:2]] = v;
        1: sm[a[3:2]] = v;
        2: begin sc[a[3:2]] = v; mcnt[a[3:2]] = 0; end
        default: if (a[3]) sd[a[3:2]] = v;
      endcase
    end
  endtask

  task automatic bus(input logic [31:0] a, input logic [31:0] d, input bit dma, input bit f,
                     input bit w, input logic [1:0] s, input string req);
    bit [3:0] m, inch, arm, lst, hit, fire;
    int fst = first_of(mmode), ech = 0, lim;
    bit eaft;
    for (int i = 0; i < 4; i++) begin
      m[i] = m_match(i, a, d, dma, f, w, s);
      inch[i] = (mmode != 0) && (i >= fst);
      arm[i] = !inch[i] || (mptr == i);
      lim = (i >= 2) ? ((sc[i][27:16] == 0) ? 1 : int'(sc[i][27:16])) : 1;
      lst[i] = (mcnt[i] + 1) >= lim;
      hit[i] = m[i] & arm[i] & lst[i];
      fire[i] = hit[i] & (!inch[i] || i == 3);
    end
    for (int i = 2; i < 4; i++)
      if (m[i] && arm[i]) mcnt[i] = lst[i] ? 0 : mcnt[i] + 1;
    if (mmode != 0 && hit[mptr] && inch[mptr]) mptr = (mptr == 3) ? fst : mptr + 1;
    for (int i = 3; i >= 0; i--) if (fire[i]) ech = i;
    eaft = (fire != 0) && sc[ech][10] && f;
    mon_valid = 1; mon_addr = a; mon_data = d; mon_dma = dma; mon_fetch = f;
    mon_write = w; mon_size = s;
    @(negedge clk);
    mon_valid = 0;
    chk(brk_irq == (fire != 0), req, "brk_irq", 32'(brk_irq), 32'(fire != 0));
    if (fire != 0) begin
      chk(brk_chan == 2'(ech), req, "brk_chan", 32'(brk_chan), 32'(ech));
      chk(brk_after == eaft, req, "brk_after", 32'(brk_after), 32'(eaft));
    end
  endtask

  task automatic br(input logic [31:0] s, input logic [31:0] d);
    br_valid = 1; br_src = s; br_dst = d;
    @(negedge clk);
    br_valid = 0;
    rs.push_front(s); rdst.push_front(d);
  endtask

  task automatic trc_check(input string req);
    for (int k = 0; k < 4; k++) begin
      bit ev = k < rs.size();
      trc_idx = 2'(k);
      #1;
      chk(trc_valid == ev, req, $sformatf("trc_valid[%0d]", k), 32'(trc_valid), 32'(ev));
      if (ev) begin
        chk(trc_src == rs[k], req, $sformatf("trc_src[%0d]", k), trc_src, rs[k]);
        chk(trc_dst == rdst[k], req, $sformatf("trc_dst[%0d]", k), trc_dst, rdst[k]);
      end
    end
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(1234));
    for (int i = 0; i < 4; i++) begin sa[i] = 0; sm[i] = 0; sc[i] = 0; sd[i] = 0; mcnt[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(brk_irq == 0, "R11", "brk_irq after reset", 32'(brk_irq), 0);
    trc_check("R11");
    bus(32'h0, 0, 0, 0, 0, 0, "R11");

    cfg(5'd0, 32'h1000); cfg(5'd1, 32'hF); cfg(5'd2, ctl(1,0,0,0,0,0,0,0,0,0,0,0));
    bus(32'h100C, 0, 1, 1, 1, 2, "R1");
    bus(32'h1010, 0, 0, 0, 0, 0, "R1");
    bus(32'h1000, 0, 0, 0, 0, 0, "R1");

    cfg(5'd4, 32'h2000); cfg(5'd5, 0); cfg(5'd6, ctl(1,0,0,0,0,1,1,1,2'd1,0,0,0));
    bus(32'h2000, 0, 0, 0, 0, 1, "R2");
    bus(32'h2000, 0, 0, 0, 1, 2, "R2");
    bus(32'h2000, 0, 0, 0, 1, 1, "R2");
    cfg(5'd6, ctl(1,1,1,1,0,0,0,0,0,0,0,0));
    bus(32'h2000, 0, 0, 0, 0, 0, "R2");
    bus(32'h2000, 0, 1, 1, 0, 0, "R2");
    bus(32'h2000, 0, 1, 0, 0, 0, "R2");
    cfg(5'd6, ctl(0,0,0,0,0,0,0,0,0,0,0,0));
    bus(32'h2000, 0, 0, 0, 0, 0, "R2");

    cfg(5'd3, 32'h55); cfg(5'd2, ctl(1,0,0,0,0,0,0,0,0,0,1,0));
    bus(32'h1004, 32'h99, 0, 0, 0, 0, "R3");
    cfg(5'd2, 0);
    cfg(5'd8, 32'h3000); cfg(5'd9, 0); cfg(5'd11, 32'h55); cfg(5'd10, ctl(1,0,0,0,0,0,0,0,0,0,1,0));
    bus(32'h3000, 32'h56, 0, 0, 0, 0, "R3");
    bus(32'h3000, 32'h55, 0, 0, 0, 0, "R3");

    cfg(5'd2, ctl(1,0,0,0,0,0,0,0,0,1,0,0)); cfg(5'd4, 32'h1000); cfg(5'd6, ctl(1,0,0,0,0,0,0,0,0,0,0,0));
    bus(32'h1000, 0, 0, 1, 0, 0, "R4 R9");
    bus(32'h1000, 0, 0, 0, 0, 0, "R9");
    cfg(5'd2, 0);
    bus(32'h1000, 0, 0, 1, 0, 0, "R4");

    cfg(5'd10, ctl(1,0,0,0,0,0,0,0,0,0,0,12'd3));
    for (int k = 0; k < 4; k++) bus(32'h3000, 0, 0, 0, 0, 0, "R8");
    cfg(5'd10, ctl(1,0,0,0,0,0,0,0,0,0,0,12'd2));
    bus(32'h3000, 0, 0, 0, 0, 0, "R8");
    cfg(5'd10, ctl(1,0,0,0,0,0,0,0,0,0,0,12'd2));
    bus(32'h3000, 0, 0, 0, 0, 0, "R8");
    bus(32'h3000, 0, 0, 0, 0, 0, "R8");

    for (int i = 0; i < 4; i++) begin
      cfg(5'(i*4), 32'h100 * (i + 1)); cfg(5'(i*4+1), 0);
      cfg(5'(i*4+2), ctl(1,0,0,0,0,0,0,0,0,0,0,0));
    end
    cfg(5'd16, 1);
    bus(32'h400, 0, 0, 0, 0, 0, "R5");
    bus(32'h100, 0, 0, 0, 0, 0, "R5");
    bus(32'h300, 0, 0, 0, 0, 0, "R5");
    bus(32'h200, 0, 0, 0, 0, 0, "R5");
    bus(32'h300, 0, 0, 0, 0, 0, "R5");
    bus(32'h400, 0, 0, 0, 0, 0, "R5");
    bus(32'h400, 0, 0, 0, 0, 0, "R7");
    bus(32'h100, 0, 0, 0, 0, 0, "R7");
    bus(32'h200, 0, 0, 0, 0, 0, "R7");
    cfg(5'd16, 1);
    bus(32'h300, 0, 0, 0, 0, 0, "R7");
    bus(32'h400, 0, 0, 0, 0, 0, "R7");
    cfg(5'd16, 3);
    bus(32'h100, 0, 0, 0, 0, 0, "R6");
    bus(32'h300, 0, 0, 0, 0, 0, "R6");
    bus(32'h400, 0, 0, 0, 0, 0, "R6");
    cfg(5'd16, 2);
    bus(32'h200, 0, 0, 0, 0, 0, "R6");
    bus(32'h300, 0, 0, 0, 0, 0, "R6");
    bus(32'h400, 0, 0, 0, 0, 0, "R6");

    br(32'hA0, 32'hB0); br(32'hA1, 32'hB1);
    trc_check("R10");
    br(32'hA2, 32'hB2); br(32'hA3, 32'hB3); br(32'hA4, 32'hB4);
    void'(rs.pop_back()); void'(rdst.pop_back());
    trc_check("R10");

    for (int n = 0; n < 3000; n++) begin
      if (n % 200 == 0) begin
        for (int i = 0; i < 4; i++) begin
          logic [31:0] c = $urandom;
          c[0] = ($urandom % 5) != 0;
          c[27:16] = 12'($urandom % 3);
          c[31:28] = 0; c[15:12] = 0;
          cfg(5'(i*4), 32'h40 + 32'h40 * ($urandom % 2));
          cfg(5'(i*4+1), ($urandom % 2) ? 32'h4 : 32'h0);
          cfg(5'(i*4+3), 32'($urandom % 2));
          cfg(5'(i*4+2), c);
        end
        cfg(5'd16, 32'($urandom % 4));
      end
      bus(32'h40 + 32'h40 * ($urandom % 2) + 32'h4 * ($urandom % 2), 32'($urandom % 2),
          1'($urandom), 1'($urandom), 1'($urandom), 2'($urandom % 3), "R4 R5 R6 R8 random");
      if ($urandom % 4 == 0) begin
        br($urandom, $urandom);
        if (rs.size() > 4) begin void'(rs.pop_back()); void'(rdst.pop_back()); end
      end
    end
    trc_check("R10");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule